// File: doc/BRIEF.md
# Synchronizable Integer Clock Divider

The block divides a fast input clock by an integer ratio from 1 to 8. It produces two outputs. The first is a one-cycle clock enable that marks the start of each output period. The second is a registered divided clock that is high during the first half of each period. Several copies of the block can share one external sync pulse. Each accepted pulse sends the divider back to the start of its period, so every copy that receives the same pulse has the same output phase afterwards.

A single control word sets the ratio and how sync behaves, and a one-cycle write strobe loads it. When sync is enabled it works in one of two modes:

- **Continuous:** every rising edge of the sync input realigns the divider.
- **One-shot:** only the first rising edge after a control write realigns it. A status flag shows when that one realignment has been used, and the next control write clears the flag and re-arms the block.

The sync input is asynchronous to the clock, so it passes through a synchronizer before edge detection.

Top module: `syncdiv_top`

## Requirements
- R1: While reset is active, and just after it, `clk_en_o` is 1, `div_clk_o` is 0 and `sync_used_o` is 0. The active ratio is 1 and sync is disabled.
- R2: The ratio field holds N-1 in bits [6:4] of the control word. With ratio N active, `clk_en_o` is high in exactly one cycle out of every N. With N = 1 it stays high.
- R3: `div_clk_o` is high in the first floor(N/2) cycles of each period, counting from the cycle in which `clk_en_o` is high. With N = 1 it stays low.
- R4: A newly written ratio becomes active only at the next period boundary or at the next accepted sync, whichever comes first.
- R5: Say `sync_i` is first sampled high at clock edge k, after being sampled low at edge k-1. If that sync is accepted, the period restarts in the cycle after edge k+2, with `clk_en_o` high in that cycle.
- R6: When control bit 1 (sync enable) is 0, sync pulses leave the outputs unchanged.
- R7: When bit 1 is 1 and bit 2 (one-shot) is 0, every sync rising edge is accepted.
- R8: When bit 1 is 1 and bit 2 is 1, only the first sync rising edge after a control write is accepted. Later edges are ignored until the next write.
- R9: `sync_used_o` goes to 1 in the cycle after a one-shot sync is accepted. It goes back to 0 in the cycle after any control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | External sync pulse, asynchronous to the clock |
| wr_en_i | input | 1 | One-cycle strobe that loads the control word |
| wr_data_i | input | 8 | Control word: bit 1 is sync enable, bit 2 is one-shot, bits [6:4] are ratio minus one |
| clk_en_o | output | 1 | One-cycle enable at the start of each output period |
| div_clk_o | output | 1 | Divided clock |
| sync_used_o | output | 1 | One-shot sync has been consumed |

## Verification
The hardest case to reach from the ports is a sync that arrives while a new ratio is still pending and the counter is partway through a period. In that case the restart and the ratio change happen on the same edge. The stimulus writes a new ratio and then sends a sync before the old period can end. It also places one-shot and disabled-mode pulses mid-period, so that an accept that should have been ignored would visibly move the phase. A cycle-level reference model in the bench predicts every output cycle, and a monitor compares the outputs against it.

// File: rtl/syncdiv_pkg.sv
package syncdiv_pkg;

  parameter int unsigned RATIO_W   = 3;
  parameter int unsigned CTRL_W    = 8;
  parameter int unsigned SYNC_STG  = 2;
  // control word field positions
  parameter int unsigned EN_BIT    = 1;
  parameter int unsigned ONESHOT_BIT = 2;
  parameter int unsigned RATIO_LSB = 4;

  typedef struct packed {
    logic               sync_en;
    logic               one_shot;
    logic [RATIO_W-1:0] ratio_m1;
  } ctrl_t;

  function automatic ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] word);
    ctrl_t c;
    c.sync_en  = word[EN_BIT];
    c.one_shot = word[ONESHOT_BIT];
    c.ratio_m1 = word[RATIO_LSB +: RATIO_W];
    return c;
  endfunction

  // number of high cycles per period: floor(N/2) with N = ratio_m1 + 1
  function automatic logic [RATIO_W:0] high_len(input logic [RATIO_W-1:0] ratio_m1);
    logic [RATIO_W:0] n;
    n = {1'b0, ratio_m1} + 1'b1;
    return n >> 1;
  endfunction

  function automatic logic at_period_end(input logic [RATIO_W-1:0] cnt,
                                         input logic [RATIO_W-1:0] ratio_m1);
    return cnt == ratio_m1;
  endfunction

endpackage

// File: rtl/syncdiv_sync_edge.sv
module syncdiv_sync_edge #(
  parameter int unsigned STAGES = syncdiv_pkg::SYNC_STG
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES:0] chain_q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= async_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R5: an edge is a single-cycle event
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/syncdiv_ctrl.sv
module syncdiv_ctrl
  import syncdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              sync_rise_i,
  output ctrl_t             ctrl_o,
  output logic              accept_o,
  output logic              used_o
);

  ctrl_t ctrl_q;
  logic  used_q;
  logic  oneshot_open;
  logic  unused_reserved;

  assign unused_reserved = ^{wr_data_i[CTRL_W-1], wr_data_i[3], wr_data_i[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= unpack_ctrl(wr_data_i);
  end

  assign oneshot_open = ~ctrl_q.one_shot | ~used_q;
  assign accept_o     = sync_rise_i & ctrl_q.sync_en & oneshot_open;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          used_q <= 1'b0;
    else if (wr_en_i)                     used_q <= 1'b0;
    else if (accept_o && ctrl_q.one_shot) used_q <= 1'b1;
  end

  assign ctrl_o = ctrl_q;
  assign used_o = used_q;

  // R8
  spent_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_q && ctrl_q.one_shot && sync_rise_i |-> !accept_o);

  // R9
  write_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !used_o);

endmodule

// File: rtl/syncdiv_counter.sv
module syncdiv_counter
  import syncdiv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               accept_i,
  input  logic [RATIO_W-1:0] ratio_req_i,
  output logic [RATIO_W-1:0] cnt_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               wrap_o,
  output logic               en_o,
  output logic               div_o
);

  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic [RATIO_W-1:0] act_q, act_d;
  logic               en_q, div_q;
  logic               wrap;

  assign wrap = at_period_end(cnt_q, act_q);

  always_comb begin
    if (accept_i || wrap) begin
      cnt_d = '0;
      act_d = ratio_req_i;
    end else begin
      cnt_d = cnt_q + 1'b1;
      act_d = act_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
      en_q  <= 1'b1;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      en_q  <= (cnt_d == '0);
      div_q <= ({1'b0, cnt_d} < high_len(act_d));
    end
  end

  assign cnt_o   = cnt_q;
  assign ratio_o = act_q;
  assign wrap_o  = wrap;
  assign en_o    = en_q;
  assign div_o   = div_q;

  // R2
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= act_q);

  // R4
  ratio_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap && !accept_i |=> $stable(act_q));

endmodule

// File: rtl/syncdiv_top.sv
module syncdiv_top
  import syncdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic              clk_en_o,
  output logic              div_clk_o,
  output logic              sync_used_o
);

  logic               sync_rise;
  logic               sync_accept;
  ctrl_t              ctrl;
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] act_ratio;
  logic               wrap;

  syncdiv_sync_edge #(.STAGES(SYNC_STG)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (sync_i),
    .rise_o  (sync_rise)
  );

  syncdiv_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .sync_rise_i (sync_rise),
    .ctrl_o      (ctrl),
    .accept_o    (sync_accept),
    .used_o      (sync_used_o)
  );

  syncdiv_counter u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (sync_accept),
    .ratio_req_i (ctrl.ratio_m1),
    .cnt_o       (cnt),
    .ratio_o     (act_ratio),
    .wrap_o      (wrap),
    .en_o        (clk_en_o),
    .div_o       (div_clk_o)
  );

  // R5
  accept_restarts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_accept |=> clk_en_o && cnt == '0);

  // R6
  disabled_free_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.sync_en && !wrap |=> cnt == RATIO_W'($past(cnt) + 1'b1));

  // R3
  period_start_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> div_clk_o == (act_ratio != '0));

  // R9
  used_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_used_o && !wr_en_i |=> sync_used_o);

endmodule

// File: tb/test_syncdiv_top.sv
module test_syncdiv_top;

  typedef struct {
    logic  en;
    logic  dv;
    logic  used;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       clk_en, div_clk, used;

  int    total = 0;
  int    bad = 0;
  bit    finished = 1'b0;
  string cur_tag = "R1";
  exp_t  sb_q[$];

  // reference state, kept from the requirements
  int       m_phase, m_len, m_req_len;
  bit       m_en_sync, m_oneshot, m_used;
  bit [2:0] m_pipe;

  always #5 clk = ~clk;

  syncdiv_top i_syncdiv_top (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sync_i      (sync),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .clk_en_o    (clk_en),
    .div_clk_o   (div_clk),
    .sync_used_o (used)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // model: one step per clock edge, pushes the expected outputs of the next cycle
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_len = 1; m_req_len = 1;
      m_en_sync = 0; m_oneshot = 0; m_used = 0; m_pipe = '0;
    end else begin
      bit took;
      exp_t e;
      took = (m_pipe[1] && !m_pipe[2]) && m_en_sync && !(m_oneshot && m_used);
      if (took || m_phase + 1 >= m_len) begin
        m_phase = 0;
        m_len   = m_req_len;
      end else begin
        m_phase++;
      end
      if (wr_en) begin
        m_used     = 0;
        m_en_sync  = wr_data[1];
        m_oneshot  = wr_data[2];
        m_req_len  = int'(wr_data[6:4]) + 1;
      end else if (took && m_oneshot) begin
        m_used = 1;
      end
      m_pipe = {m_pipe[1:0], sync};
      e.en   = (m_phase == 0);
      e.dv   = (m_phase < m_len / 2);
      e.used = m_used;
      e.tag  = cur_tag;
      sb_q.push_back(e);
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, "clk_en_o", int'(clk_en), int'(e.en));
      check(e.tag, "div_clk_o", int'(div_clk), int'(e.dv));
      check(e.tag, "sync_used_o", int'(used), int'(e.used));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctrl(input bit sen, input bit os, input int n);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = '0;
    wr_data[1]   = sen;
    wr_data[2]   = os;
    wr_data[6:4] = 3'(n - 1);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_sync();
    @(negedge clk);
    sync = 1'b1;
    idle(2);
    sync = 1'b0;
  endtask

  initial begin
    idle(2);
    // R1: outputs while reset is held
    check("R1", "clk_en_o", int'(clk_en), 1);
    check("R1", "div_clk_o", int'(div_clk), 0);
    check("R1", "sync_used_o", int'(used), 0);
    rst_n = 1'b1;
    cur_tag = "R1,R3";
    idle(8);
    for (int n = 2; n <= 8; n++) begin
      cur_tag = "R2,R3";
      write_ctrl(1'b0, 1'b0, n);
      idle(3 * n + 4);
    end
    cur_tag = "R4";
    write_ctrl(1'b0, 1'b0, 8);
    idle(11);
    write_ctrl(1'b0, 1'b0, 3);
    idle(20);
    cur_tag = "R6";
    write_ctrl(1'b0, 1'b0, 7);
    idle(3);
    for (int k = 0; k < 3; k++) begin
      pulse_sync();
      idle(4 + k);
    end
    cur_tag = "R7";
    write_ctrl(1'b1, 1'b0, 7);
    idle(2);
    for (int k = 0; k < 4; k++) begin
      pulse_sync();
      idle(3 + 2 * k);
    end
    cur_tag = "R5,R4";
    write_ctrl(1'b1, 1'b0, 8);
    idle(10);
    write_ctrl(1'b1, 1'b0, 4);
    pulse_sync();
    idle(14);
    cur_tag = "R8";
    write_ctrl(1'b1, 1'b1, 5);
    idle(3);
    pulse_sync();
    idle(6);
    pulse_sync();
    idle(5);
    pulse_sync();
    idle(8);
    cur_tag = "R9";
    write_ctrl(1'b1, 1'b1, 6);
    idle(2);
    pulse_sync();
    idle(9);
    write_ctrl(1'b1, 1'b1, 6);
    idle(4);
    idle(5);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule